// File: doc/BRIEF.md
# Display control register decoder

This block sits behind the control port of a graphics controller. Each 32-bit write carries a command number in its top byte and the command's parameters in the low 24 bits. The decoder keeps the display-control state: the blanking flag, the DMA direction field, the scan-out origin, the horizontal and vertical display windows and the video mode bits. It packs the flag and field state into a status word. Info-query commands copy masked drawing settings into a read-data register.

A write is dropped when it repeats the value last accepted for the same command. This holds for every command from 2 to 8 except the origin command, so software that rewrites an unchanged setting sees no update pulse. The block also emits single-cycle pulses for a full reset, for a command-queue flush, for a changed scan-out origin and for every accepted write. Downstream logic uses these pulses to flush queues and to redraw.

Top module: `disp_ctl_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `statusWord` becomes 0x14802000. `readData`, the origin outputs, the window outputs and all pulse outputs become 0.
- R2: Command 0x00 loads `statusWord` with 0x14802000 and clears `readData`. It pulses `resetPulse`, `fifoResetPulse` and `ctlUpdate` for one cycle, and leaves the origin and window outputs unchanged.
- R3: Command 0x01 pulses `fifoResetPulse` and `ctlUpdate` for one cycle. It changes neither `statusWord`, `readData`, the origin nor the windows.
- R4: Command 0x03 copies data bit 0 into status bit 23 (blanking).
- R5: Command 0x04 copies data bits 1:0 into status bits 30:29 (DMA direction).
- R6: Command 0x05 sets `srcX` from data bits 9:0 and `srcY` from data bits 18:10. `originChg` pulses only when either value differs from the one held. This command is never dropped as a repeat, so `ctlUpdate` fires on every write of it.
- R7: Command 0x06 sets `hStart` from data bits 11:0 and `hEnd` from bits 23:12. Command 0x07 sets `vStart` from data bits 9:0 and `vEnd` from bits 19:10.
- R8: Command 0x08 replaces status bits 22:16: data bits 5:0 go to status bits 22:17 and data bit 6 goes to status bit 16.
- R9: Commands 0x10 to 0x1F select a query by data bits 3:0. Query 2 loads `readData` with `texWinCfg[19:0]`, query 3 with `drawAreaLo[19:0]` and query 4 with `drawAreaHi[19:0]`, zero-extended in each case. Query 5 loads `drawOffset[21:0]`, zero-extended, and query 7 loads the constant 2.
- R10: A query whose selector is not 2, 3, 4, 5 or 7 leaves `readData` unchanged.
- R11: A write of command 2, 3, 4, 6, 7 or 8 whose full 32-bit word equals the last accepted word of that command is dropped. It has no effect on any output and `ctlUpdate` stays low. `rst` and command 0x00 forget all stored words, so the first write of each command after a reset is accepted.
- R12: `ctlUpdate` goes high for exactly one cycle after each accepted write and stays low after cycles without a write. All register changes appear at the clock edge that samples `wrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Control-port write strobe |
| wrData | input | 32 | Control-port write word (command in bits 31:24) |
| texWinCfg | input | 32 | Drawing setting returned by query 2 |
| drawAreaLo | input | 32 | Drawing setting returned by query 3 |
| drawAreaHi | input | 32 | Drawing setting returned by query 4 |
| drawOffset | input | 32 | Drawing setting returned by query 5 |
| statusWord | output | 32 | Packed status word |
| readData | output | 32 | Read-data register loaded by queries |
| srcX | output | 10 | Scan-out origin X |
| srcY | output | 9 | Scan-out origin Y |
| hStart | output | 12 | Horizontal display window start |
| hEnd | output | 12 | Horizontal display window end |
| vStart | output | 10 | Vertical display window start |
| vEnd | output | 10 | Vertical display window end |
| ctlUpdate | output | 1 | One-cycle pulse per accepted write |
| resetPulse | output | 1 | One-cycle pulse on command 0x00 |
| fifoResetPulse | output | 1 | One-cycle pulse on command 0x00 or 0x01 |
| originChg | output | 1 | One-cycle pulse when the scan-out origin changes |

## Verification
Repeat suppression is the hardest case to observe, because a dropped write would have produced the state the block already holds. The only visible trace is the missing `ctlUpdate` pulse. The stimulus therefore writes the same word twice in a row for several commands, and expects a pulse only on the first write. It then issues a full-reset command and repeats one of those earlier words, which must now be accepted again. The origin command is repeated in the same way and must keep pulsing `ctlUpdate` while `originChg` stays low.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;

  localparam logic [31:0] StatusResetVal = 32'h1480_2000;
  localparam int BlankBit = 23;
  localparam int DmaLo    = 29;
  localparam int ModeLo   = 16;

  typedef enum logic [7:0] {
    CmdFullReset = 8'h00,
    CmdFifoFlush = 8'h01,
    CmdBlank     = 8'h03,
    CmdDmaDir    = 8'h04,
    CmdOrigin    = 8'h05,
    CmdHWindow   = 8'h06,
    CmdVWindow   = 8'h07,
    CmdVidMode   = 8'h08
  } ctlCmd_e;

  typedef struct packed {
    logic accept;
    logic doReset;
    logic doFifoReset;
    logic setBlank;
    logic setDma;
    logic setOrigin;
    logic setHWin;
    logic setVWin;
    logic setMode;
    logic doQuery;
  } ctlStrobe_t;

endpackage

// File: rtl/disp_ctl_control.sv
module disp_ctl_control
  import disp_ctl_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int NumShadow = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [DataW-1:0] wrData,
  output ctlStrobe_t       strb
);
  localparam int CmdLsb = DataW - 8;

  logic [7:0]       cmd;
  logic [DataW-1:0] shadowQ [NumShadow];
  logic             dupHit;

  assign cmd = wrData[DataW-1:CmdLsb];

  // Repeat detection against the last accepted word per command
  always_comb begin
    dupHit = 1'b0;
    for (int i = 2; i < NumShadow; i++) begin
      if (i != int'(CmdOrigin) && cmd == 8'(i) && shadowQ[i] == wrData)
        dupHit = 1'b1;
    end
  end

  always_comb begin
    strb             = '0;
    strb.accept      = wrEn && !dupHit;
    strb.doReset     = strb.accept && cmd == CmdFullReset;
    strb.doFifoReset = strb.accept && cmd == CmdFifoFlush;
    strb.setBlank    = strb.accept && cmd == CmdBlank;
    strb.setDma      = strb.accept && cmd == CmdDmaDir;
    strb.setOrigin   = strb.accept && cmd == CmdOrigin;
    strb.setHWin     = strb.accept && cmd == CmdHWindow;
    strb.setVWin     = strb.accept && cmd == CmdVWindow;
    strb.setMode     = strb.accept && cmd == CmdVidMode;
    strb.doQuery     = strb.accept && cmd[7:4] == 4'h1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NumShadow; i++) begin
      if (rst || strb.doReset)
        shadowQ[i] <= (i == int'(CmdBlank)) ? DataW'(1) : '0;
      else if (strb.accept && cmd == 8'(i))
        shadowQ[i] <= wrData;
    end
  end

endmodule

// File: rtl/disp_ctl_datapath.sv
module disp_ctl_datapath
  import disp_ctl_pkg::*;
#(
  parameter int DataW = 32,
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int HW    = 12,
  parameter int VW    = 10,
  parameter int QLoW  = 20,
  parameter int QOffW = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       strb,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] texWinCfg,
  input  logic [DataW-1:0] drawAreaLo,
  input  logic [DataW-1:0] drawAreaHi,
  input  logic [DataW-1:0] drawOffset,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] readData,
  output logic [XW-1:0]    srcX,
  output logic [YW-1:0]    srcY,
  output logic [HW-1:0]    hStart,
  output logic [HW-1:0]    hEnd,
  output logic [VW-1:0]    vStart,
  output logic [VW-1:0]    vEnd,
  output logic             ctlUpdate,
  output logic             resetPulse,
  output logic             fifoResetPulse,
  output logic             originChg
);
  localparam int ModeW = 7;

  logic [XW-1:0]    newX;
  logic [YW-1:0]    newY;
  logic             originDiff;
  logic             queryHit;
  logic [DataW-1:0] queryVal;

  assign newX       = wrData[XW-1:0];
  assign newY       = wrData[XW+YW-1:XW];
  assign originDiff = (newX != srcX) || (newY != srcY);

  // Info query selection on the low nibble
  always_comb begin
    queryHit = 1'b1;
    queryVal = '0;
    unique case (wrData[3:0])
      4'h2:    queryVal = DataW'(texWinCfg[QLoW-1:0]);
      4'h3:    queryVal = DataW'(drawAreaLo[QLoW-1:0]);
      4'h4:    queryVal = DataW'(drawAreaHi[QLoW-1:0]);
      4'h5:    queryVal = DataW'(drawOffset[QOffW-1:0]);
      4'h7:    queryVal = DataW'(2);
      default: queryHit = 1'b0;
    endcase
  end

  // Status word and read-data register
  always_ff @(posedge clk) begin
    if (rst || strb.doReset) begin
      statusWord <= StatusResetVal;
      readData   <= '0;
    end else begin
      if (strb.setBlank)
        statusWord[BlankBit] <= wrData[0];
      if (strb.setDma)
        statusWord[DmaLo+1:DmaLo] <= wrData[1:0];
      if (strb.setMode)
        statusWord[ModeLo+ModeW-1:ModeLo] <= {wrData[5:0], wrData[6]};
      if (strb.doQuery && queryHit)
        readData <= queryVal;
    end
  end

  // Display origin and windows (kept across a command reset)
  always_ff @(posedge clk) begin
    if (rst) begin
      srcX   <= '0;
      srcY   <= '0;
      hStart <= '0;
      hEnd   <= '0;
      vStart <= '0;
      vEnd   <= '0;
    end else begin
      if (strb.setOrigin && originDiff) begin
        srcX <= newX;
        srcY <= newY;
      end
      if (strb.setHWin) begin
        hStart <= wrData[HW-1:0];
        hEnd   <= wrData[2*HW-1:HW];
      end
      if (strb.setVWin) begin
        vStart <= wrData[VW-1:0];
        vEnd   <= wrData[2*VW-1:VW];
      end
    end
  end

  // Event pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      ctlUpdate      <= 1'b0;
      resetPulse     <= 1'b0;
      fifoResetPulse <= 1'b0;
      originChg      <= 1'b0;
    end else begin
      ctlUpdate      <= strb.accept;
      resetPulse     <= strb.doReset;
      fifoResetPulse <= strb.doReset || strb.doFifoReset;
      originChg      <= strb.setOrigin && originDiff;
    end
  end

endmodule

// File: rtl/disp_ctl_decoder.sv
module disp_ctl_decoder
  import disp_ctl_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int NumShadow = 9,
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int HW        = 12,
  parameter int VW        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] texWinCfg,
  input  logic [DataW-1:0] drawAreaLo,
  input  logic [DataW-1:0] drawAreaHi,
  input  logic [DataW-1:0] drawOffset,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] readData,
  output logic [XW-1:0]    srcX,
  output logic [YW-1:0]    srcY,
  output logic [HW-1:0]    hStart,
  output logic [HW-1:0]    hEnd,
  output logic [VW-1:0]    vStart,
  output logic [VW-1:0]    vEnd,
  output logic             ctlUpdate,
  output logic             resetPulse,
  output logic             fifoResetPulse,
  output logic             originChg
);
  ctlStrobe_t strb;

  disp_ctl_control #(.DataW(DataW), .NumShadow(NumShadow)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  disp_ctl_datapath #(.DataW(DataW), .XW(XW), .YW(YW), .HW(HW), .VW(VW)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .texWinCfg(texWinCfg), .drawAreaLo(drawAreaLo),
    .drawAreaHi(drawAreaHi), .drawOffset(drawOffset),
    .statusWord(statusWord), .readData(readData),
    .srcX(srcX), .srcY(srcY), .hStart(hStart), .hEnd(hEnd),
    .vStart(vStart), .vEnd(vEnd), .ctlUpdate(ctlUpdate),
    .resetPulse(resetPulse), .fifoResetPulse(fifoResetPulse),
    .originChg(originChg)
  );

endmodule

// File: rtl/disp_ctl_checker.sv
module disp_ctl_checker (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] statusWord,
  input logic [31:0] readData,
  input logic [9:0]  srcX,
  input logic [8:0]  srcY,
  input logic        ctlUpdate,
  input logic        resetPulse,
  input logic        fifoResetPulse,
  input logic        originChg
);

  // R2
  full_reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    resetPulse |-> (statusWord == 32'h1480_2000 && readData == 32'd0 && fifoResetPulse));

  // R3
  fifo_flush_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[31:24] == 8'h01) |=> (fifoResetPulse && !resetPulse && $stable(statusWord)));

  // R6
  origin_pulse_real_change_chk: assert property (@(posedge clk) disable iff (rst)
    originChg |-> (srcX != $past(srcX) || srcY != $past(srcY)));

  // R8
  mode_bits_placed_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[31:24] == 8'h08) |=>
      (statusWord[22:16] == {$past(wrData[5:0]), $past(wrData[6])}));

  // R9
  query_constant_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[31:28] == 4'h1 && wrData[3:0] == 4'h7) |=> (readData == 32'd2));

  // R12
  idle_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> (!ctlUpdate && $stable(statusWord) && $stable(readData)));

endmodule

bind disp_ctl_decoder disp_ctl_checker chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
  .statusWord(statusWord), .readData(readData), .srcX(srcX), .srcY(srcY),
  .ctlUpdate(ctlUpdate), .resetPulse(resetPulse),
  .fifoResetPulse(fifoResetPulse), .originChg(originChg)
);

// File: tb/disp_ctl_decoder_tb_top.sv
module disp_ctl_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] texWinCfg  = 32'hABCD_EF12;
  logic [31:0] drawAreaLo = 32'h1234_5678;
  logic [31:0] drawAreaHi = 32'hFFFF_FFFF;
  logic [31:0] drawOffset = 32'hFFFF_FFFF;
  logic [31:0] statusWord, readData;
  logic [9:0]  srcX;
  logic [8:0]  srcY;
  logic [11:0] hStart, hEnd;
  logic [9:0]  vStart, vEnd;
  logic        ctlUpdate, resetPulse, fifoResetPulse, originChg;

  always #2.5 clk = ~clk;

  disp_ctl_decoder dut_i (.*);

  typedef struct packed {
    logic [31:0] st;
    logic [31:0] rd;
    logic [9:0]  x;
    logic [8:0]  y;
    logic [11:0] hs, he;
    logic [9:0]  vs, ve;
    logic [3:0]  pul;   // {ctlUpdate, resetPulse, fifoResetPulse, originChg}
  } snap_t;

  snap_t   expQ[$];
  string   tagQ[$];
  int      checks = 0;
  int      fails  = 0;
  bit      done   = 1'b0;

  // Reference model state
  logic [31:0] mSt, mRd;
  logic [9:0]  mX;
  logic [8:0]  mY;
  logic [11:0] mHs, mHe;
  logic [9:0]  mVs, mVe;
  logic [31:0] mShadow [9];

  function automatic snap_t mkSnap(logic [3:0] pul);
    snap_t s;
    s.st = mSt; s.rd = mRd; s.x = mX; s.y = mY;
    s.hs = mHs; s.he = mHe; s.vs = mVs; s.ve = mVe; s.pul = pul;
    return s;
  endfunction

  task automatic modelReset(bit full);
    mSt = 32'h1480_2000;
    mRd = '0;
    for (int i = 0; i < 9; i++) mShadow[i] = (i == 3) ? 32'd1 : 32'd0;
    if (full) begin
      mX = '0; mY = '0; mHs = '0; mHe = '0; mVs = '0; mVe = '0;
    end
  endtask

  // Driver: drives one write and pushes the expected result
  task automatic doWrite(logic [31:0] d, string tag);
    logic [7:0] c;
    logic       acc, rp, fp, oc;
    c   = d[31:24];
    acc = !(c >= 8'd2 && c <= 8'd8 && c != 8'd5 && mShadow[c[3:0]] == d);
    rp = 1'b0; fp = 1'b0; oc = 1'b0;
    if (acc) begin
      if (c <= 8'd8) mShadow[c[3:0]] = d;
      case (c)
        8'h00: begin modelReset(1'b0); rp = 1'b1; fp = 1'b1; end
        8'h01: fp = 1'b1;
        8'h03: mSt[23] = d[0];
        8'h04: mSt[30:29] = d[1:0];
        8'h05: if (d[9:0] != mX || d[18:10] != mY) begin
                 mX = d[9:0]; mY = d[18:10]; oc = 1'b1;
               end
        8'h06: begin mHs = d[11:0]; mHe = d[23:12]; end
        8'h07: begin mVs = d[9:0];  mVe = d[19:10]; end
        8'h08: mSt[22:16] = {d[5:0], d[6]};
        default: if (c[7:4] == 4'h1) begin
          case (d[3:0])
            4'h2: mRd = {12'd0, texWinCfg[19:0]};
            4'h3: mRd = {12'd0, drawAreaLo[19:0]};
            4'h4: mRd = {12'd0, drawAreaHi[19:0]};
            4'h5: mRd = {10'd0, drawOffset[21:0]};
            4'h7: mRd = 32'd2;
            default: ;
          endcase
        end
      endcase
    end
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    #1;
    expQ.push_back(mkSnap({acc, rp, fp, oc}));
    tagQ.push_back(tag);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idleCheck(string tag);
    @(negedge clk);
    #1;
    expQ.push_back(mkSnap(4'b0000));
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      snap_t e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a.st = statusWord; a.rd = readData; a.x = srcX; a.y = srcY;
      a.hs = hStart; a.he = hEnd; a.vs = vStart; a.ve = vEnd;
      a.pul = {ctlUpdate, resetPulse, fifoResetPulse, originChg};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual st=%h rd=%h x=%h y=%h h=%h/%h v=%h/%h pul=%b expected st=%h rd=%h x=%h y=%h h=%h/%h v=%h/%h pul=%b",
                 t, a.st, a.rd, a.x, a.y, a.hs, a.he, a.vs, a.ve, a.pul,
                 e.st, e.rd, e.x, e.y, e.hs, e.he, e.vs, e.ve, e.pul);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset(1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idleCheck("R1 reset state");

    doWrite(32'h0300_0000, "R4 unblank");
    idleCheck("R12 pulse ends");
    doWrite(32'h0300_0000, "R11 repeated blank dropped");
    doWrite(32'h0300_0001, "R4 blank");
    doWrite(32'h0400_0002, "R5 dma direction");
    doWrite(32'h0400_0002, "R11 repeated dma dropped");
    doWrite(32'h0500_0000 | (32'h1AB << 10) | 32'h3FF, "R6 origin change");
    doWrite(32'h0500_0000 | (32'h1AB << 10) | 32'h3FF, "R6 same origin no change pulse");
    doWrite(32'h0500_0000 | (32'h1AB << 10) | 32'h000, "R6 origin X change");
    doWrite(32'h06C6_0260, "R7 horizontal window");
    doWrite(32'h0704_0010, "R7 vertical window");
    doWrite(32'h0704_0010, "R11 repeated vertical dropped");
    doWrite(32'h0800_0055, "R8 mode bits");
    doWrite(32'h0800_002A, "R8 mode bits other");
    doWrite(32'h1000_0002, "R9 query 2");
    doWrite(32'h1000_0003, "R9 query 3");
    doWrite(32'h1000_0004, "R9 query 4");
    doWrite(32'h1000_0005, "R9 query 5");
    doWrite(32'h1000_0009, "R10 unknown query keeps data");
    doWrite(32'h1F00_0007, "R9 query 7");
    doWrite(32'h1000_000F, "R10 unknown query keeps constant");
    doWrite(32'h0100_0000, "R3 fifo flush");
    idleCheck("R12 pulses clear after flush");
    doWrite(32'h0000_0000, "R2 full reset command");
    idleCheck("R2 pulses single cycle");
    doWrite(32'h0400_0002, "R11 stored words forgotten after reset");
    doWrite(32'h0200_0007, "R11 first write of command 2");
    doWrite(32'h0200_0007, "R11 repeated command 2 dropped");
    doWrite(32'h0900_0000, "R12 unused command still accepted");
    idleCheck("R12 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule